// File: doc/BRIEF.md
# Multi-Slot Proximity Collision Scanner

This block decides which entries of a table of enemy objects lie too close to one reference object, such as the player's craft or a projectile. A start strobe captures the reference position, the two per-axis minimum separations and a border margin. The block then walks the enemy table one slot per clock. A slot counts as a collision when it is marked valid and its distance to the reference is below the minimum separation on the x axis and also below the minimum separation on the y axis.

When the walk ends, the block raises a one-cycle done pulse. The per-slot hit vector, the any-hit flag and a border flag then stay fixed until the next accepted start. The border flag reports a reference position that lies within the margin of any screen edge. The caller chooses what to do with the results, for example ending the game or retiring the enemies that were hit. The enemy table is read live during the walk, so the caller keeps it steady from the start strobe until done.

Top module: `prox_collide_scan`

## Requirements
- R1: Slot k's bit in `hit_vec` is set when |enemy_x[k]−ref_x| < min_dx and |enemy_y[k]−ref_y| < min_dy. A separation exactly equal to the minimum on either axis is not a hit. Slot k occupies bits [k*COORD_W +: COORD_W] of the flat coordinate buses.
- R2: Distances are true absolute differences, so an enemy on either side of the reference is treated the same way. A large coordinate never wraps into a false hit.
- R3: A slot whose bit in `enemy_valid` is 0 never sets its `hit_vec` bit.
- R4: An accepted start on clock edge E0 makes `busy` rise after E0. `busy` falls and `done` rises after edge E(NUM_SLOTS), and `done` is high for exactly one cycle.
- R5: `any_hit` is high exactly when `hit_vec` has at least one bit set, whenever the block is not scanning.
- R6: An accepted start clears `hit_vec` and `any_hit`. From `done` until the next accepted start, `hit_vec`, `any_hit` and `border_hit` do not change, even if the enemy table changes.
- R7: A start that arrives while `busy` is high is ignored and does not shift the timing of `done`.
- R8: `border_hit` is set from the start-cycle values when ref_x < margin, or ref_x > SCREEN_W − margin, or ref_y < margin, or ref_y > SCREEN_H − margin.
- R9: While reset is asserted and after its release, `busy`, `done`, `hit_vec`, `any_hit` and `border_hit` are 0.
- R10: The reference position and both minimum separations are captured at the accepted start. Changing them during a scan does not affect that scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan; accepted only when idle |
| ref_x | input | COORD_W | Reference object x |
| ref_y | input | COORD_W | Reference object y |
| enemy_x | input | NUM_SLOTS*COORD_W | Enemy x coordinates, slot k at bits [k*COORD_W +: COORD_W] |
| enemy_y | input | NUM_SLOTS*COORD_W | Enemy y coordinates, same packing |
| enemy_valid | input | NUM_SLOTS | Per-slot occupied flag |
| min_dx | input | COORD_W | Minimum x separation |
| min_dy | input | COORD_W | Minimum y separation |
| margin | input | COORD_W | Border margin |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| hit_vec | output | NUM_SLOTS | Per-slot collision result |
| any_hit | output | 1 | At least one slot hit |
| border_hit | output | 1 | Reference within margin of a screen edge |

## Verification
The main function is tried with a mixed table: enemies placed on each side of the reference, enemies at exactly the minimum separation on one axis, an invalid slot placed on top of the reference, and distant slots. Together these separate a strict comparison from a non-strict one and a one-sided difference from an absolute one. A second pattern puts the reference near coordinate 0 and an enemy near the largest coordinate, which exposes wrapping subtraction. Separate scans move the reference onto and just past each border threshold, change inputs during and after a scan, and pulse start while busy, which isolates the capture, hold and ignore rules.

// File: rtl/prox_collide_pkg.sv
package prox_collide_pkg;

  localparam int ARITH_W = 16;

  typedef logic [ARITH_W-1:0] coord_t;

  // Absolute separation of two coordinates; never wraps.
  function automatic coord_t abs_gap(input coord_t a, input coord_t b);
    if (a >= b) return a - b;
    else        return b - a;
  endfunction

  // Both axis separations strictly below their minimums.
  function automatic logic within_pair(input coord_t ax, input coord_t ay,
                                       input coord_t bx, input coord_t by,
                                       input coord_t mx, input coord_t my);
    return (abs_gap(ax, bx) < mx) && (abs_gap(ay, by) < my);
  endfunction

  // Position closer than the margin to 0 or to the extent.
  function automatic logic outside_band(input coord_t pos, input coord_t mrg,
                                        input coord_t extent);
    logic [ARITH_W:0] upper;
    if (mrg > extent) return 1'b1;
    upper = {1'b0, extent} - {1'b0, mrg};
    return (pos < mrg) || ({1'b0, pos} > upper);
  endfunction

endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             accept,
  output logic             last_slot
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  assign accept    = start && !busy;
  assign last_slot = busy && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (last_slot) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (busy) begin
      idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/slot_select.sv
module slot_select #(
  parameter int NUM_SLOTS = 8,
  parameter int COORD_W   = 10,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS*COORD_W-1:0] flat_x,
  input  logic [NUM_SLOTS*COORD_W-1:0] flat_y,
  input  logic [NUM_SLOTS-1:0]         flat_valid,
  input  logic [IDX_W-1:0]             idx,
  output logic [COORD_W-1:0]           sel_x,
  output logic [COORD_W-1:0]           sel_y,
  output logic                         sel_valid
);
  logic [COORD_W-1:0] xs [NUM_SLOTS];
  logic [COORD_W-1:0] ys [NUM_SLOTS];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_unpack
    assign xs[k] = flat_x[k*COORD_W +: COORD_W];
    assign ys[k] = flat_y[k*COORD_W +: COORD_W];
  end

  always_comb begin
    sel_x     = xs[idx];
    sel_y     = ys[idx];
    sel_valid = flat_valid[idx];
  end
endmodule

// File: rtl/proximity_cmp.sv
module proximity_cmp
  import prox_collide_pkg::*;
#(
  parameter int COORD_W = 10
) (
  input  logic [COORD_W-1:0] ax,
  input  logic [COORD_W-1:0] ay,
  input  logic [COORD_W-1:0] bx,
  input  logic [COORD_W-1:0] by,
  input  logic [COORD_W-1:0] mx,
  input  logic [COORD_W-1:0] my,
  input  logic               valid,
  output logic               hit
);
  assign hit = valid && within_pair(coord_t'(ax), coord_t'(ay),
                                    coord_t'(bx), coord_t'(by),
                                    coord_t'(mx), coord_t'(my));
endmodule

// File: rtl/border_check.sv
module border_check
  import prox_collide_pkg::*;
#(
  parameter int COORD_W  = 10,
  parameter int SCREEN_W = 640,
  parameter int SCREEN_H = 480
) (
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic [COORD_W-1:0] mrg,
  output logic               near_edge
);
  localparam coord_t EXT_X = coord_t'(SCREEN_W);
  localparam coord_t EXT_Y = coord_t'(SCREEN_H);

  logic edge_x;
  logic edge_y;

  assign edge_x    = outside_band(coord_t'(pos_x), coord_t'(mrg), EXT_X);
  assign edge_y    = outside_band(coord_t'(pos_y), coord_t'(mrg), EXT_Y);
  assign near_edge = edge_x || edge_y;
endmodule

// File: rtl/prox_collide_scan.sv
module prox_collide_scan #(
  parameter int NUM_SLOTS = 8,
  parameter int COORD_W   = 10,
  parameter int SCREEN_W  = 640,
  parameter int SCREEN_H  = 480
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [COORD_W-1:0]           ref_x,
  input  logic [COORD_W-1:0]           ref_y,
  input  logic [NUM_SLOTS*COORD_W-1:0] enemy_x,
  input  logic [NUM_SLOTS*COORD_W-1:0] enemy_y,
  input  logic [NUM_SLOTS-1:0]         enemy_valid,
  input  logic [COORD_W-1:0]           min_dx,
  input  logic [COORD_W-1:0]           min_dy,
  input  logic [COORD_W-1:0]           margin,
  output logic                         busy,
  output logic                         done,
  output logic [NUM_SLOTS-1:0]         hit_vec,
  output logic                         any_hit,
  output logic                         border_hit
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  // Named internal events, visible to the bound checker.
  logic [IDX_W-1:0]   scan_idx;
  logic               accept;
  logic               last_slot;
  logic [COORD_W-1:0] cur_x;
  logic [COORD_W-1:0] cur_y;
  logic               cur_valid;
  logic               slot_hit;
  logic               edge_now;

  logic [COORD_W-1:0] ref_x_q;
  logic [COORD_W-1:0] ref_y_q;
  logic [COORD_W-1:0] min_dx_q;
  logic [COORD_W-1:0] min_dy_q;

  scan_sequencer #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .idx       (scan_idx),
    .accept    (accept),
    .last_slot (last_slot)
  );

  slot_select #(.NUM_SLOTS(NUM_SLOTS), .COORD_W(COORD_W)) u_sel (
    .flat_x     (enemy_x),
    .flat_y     (enemy_y),
    .flat_valid (enemy_valid),
    .idx        (scan_idx),
    .sel_x      (cur_x),
    .sel_y      (cur_y),
    .sel_valid  (cur_valid)
  );

  proximity_cmp #(.COORD_W(COORD_W)) u_cmp (
    .ax    (ref_x_q),
    .ay    (ref_y_q),
    .bx    (cur_x),
    .by    (cur_y),
    .mx    (min_dx_q),
    .my    (min_dy_q),
    .valid (cur_valid),
    .hit   (slot_hit)
  );

  border_check #(.COORD_W(COORD_W), .SCREEN_W(SCREEN_W), .SCREEN_H(SCREEN_H)) u_edge (
    .pos_x     (ref_x),
    .pos_y     (ref_y),
    .mrg       (margin),
    .near_edge (edge_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_x_q  <= '0;
      ref_y_q  <= '0;
      min_dx_q <= '0;
      min_dy_q <= '0;
    end else if (accept) begin
      ref_x_q  <= ref_x;
      ref_y_q  <= ref_y;
      min_dx_q <= min_dx;
      min_dy_q <= min_dy;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_vec    <= '0;
      any_hit    <= 1'b0;
      border_hit <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= last_slot;
      if (accept) begin
        hit_vec    <= '0;
        any_hit    <= 1'b0;
        border_hit <= edge_now;
      end else if (busy && slot_hit) begin
        hit_vec[scan_idx] <= 1'b1;
        any_hit           <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prox_collide_scan_chk.sv
module prox_collide_scan_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [NUM_SLOTS-1:0] hit_vec,
  input logic                 any_hit,
  input logic                 border_hit,
  input logic                 slot_hit,
  input logic                 cur_valid,
  input logic [IDX_W-1:0]     scan_idx
);
  a_r3_invalid_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    slot_hit |-> cur_valid);

  a_r1_hit_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot_hit) |=> hit_vec[$past(scan_idx)]);

  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_done_ends_scan: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r5_any_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (any_hit == (hit_vec != '0)));

  a_r6_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hit_vec) && $stable(any_hit) && $stable(border_hit)));

  a_r7_start_ignored_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));
endmodule

bind prox_collide_scan prox_collide_scan_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .hit_vec    (hit_vec),
  .any_hit    (any_hit),
  .border_hit (border_hit),
  .slot_hit   (slot_hit),
  .cur_valid  (cur_valid),
  .scan_idx   (scan_idx)
);

// File: tb/test_prox_collide_scan.sv
module test_prox_collide_scan;
  localparam int N  = 8;
  localparam int CW = 10;
  localparam int SW = 640;
  localparam int SH = 480;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] ref_x = '0, ref_y = '0, min_dx = '0, min_dy = '0, margin = '0;
  logic [N*CW-1:0] enemy_x, enemy_y;
  logic [N-1:0] enemy_valid;
  logic busy, done, any_hit, border_hit;
  logic [N-1:0] hit_vec;

  int ex [N];
  int ey [N];
  bit ev [N];

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      enemy_x[k*CW +: CW] = CW'(ex[k]);
      enemy_y[k*CW +: CW] = CW'(ey[k]);
      enemy_valid[k]      = ev[k];
    end
  end

  prox_collide_scan #(.NUM_SLOTS(N), .COORD_W(CW), .SCREEN_W(SW), .SCREEN_H(SH)) i_prox_collide_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_x(ref_x), .ref_y(ref_y),
    .enemy_x(enemy_x), .enemy_y(enemy_y), .enemy_valid(enemy_valid),
    .min_dx(min_dx), .min_dy(min_dy), .margin(margin),
    .busy(busy), .done(done), .hit_vec(hit_vec), .any_hit(any_hit), .border_hit(border_hit)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Behavioural reference model.
  bit m_busy = 0, m_done = 0, m_any = 0, m_border = 0;
  int m_idx = 0, m_rx = 0, m_ry = 0, m_mx = 0, m_my = 0;
  bit m_hits [N];

  function automatic int mag(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int hits_word();
    int w = 0;
    for (int k = 0; k < N; k++) if (m_hits[k]) w |= (1 << k);
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_any = 0; m_border = 0; m_idx = 0;
      for (int k = 0; k < N; k++) m_hits[k] = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (ev[m_idx] && mag(ex[m_idx] - m_rx) < m_mx && mag(ey[m_idx] - m_ry) < m_my) begin
          m_hits[m_idx] = 1; m_any = 1;
        end
        if (m_idx == N - 1) begin m_busy = 0; m_done = 1; m_idx = 0; end
        else m_idx++;
      end else if (start) begin
        m_rx = ref_x; m_ry = ref_y; m_mx = min_dx; m_my = min_dy;
        m_busy = 1; m_idx = 0; m_any = 0;
        for (int k = 0; k < N; k++) m_hits[k] = 0;
        m_border = (int'(ref_x) < int'(margin)) || (int'(ref_x) > SW - int'(margin)) ||
                   (int'(ref_y) < int'(margin)) || (int'(ref_y) > SH - int'(margin));
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4", "busy", busy, m_busy);
      check("R4", "done", done, m_done);
      check("R1", "hit_vec", hit_vec, hits_word());
      check("R5", "any_hit", any_hit, m_any);
      check("R8", "border_hit", border_hit, m_border);
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL R4 watchdog: actual %0d expected %0d", cycles, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_scan();
    pulse_start();
    repeat (N) @(negedge clk);
    check("R4", "done at slot count", done, 1);
    @(negedge clk);
    check("R4", "done single cycle", done, 0);
  endtask

  task automatic clear_table();
    for (int k = 0; k < N; k++) begin ex[k] = 600; ey[k] = 20; ev[k] = 0; end
  endtask

  initial begin
    clear_table();
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "busy in reset", busy, 0);
    check("R9", "hit_vec in reset", hit_vec, 0);
    check("R9", "border in reset", border_hit, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "done after reset", done, 0);
    check("R9", "any_hit after reset", any_hit, 0);

    // Mixed table
    ref_x = 300; ref_y = 200; min_dx = 10; min_dy = 8; margin = 16;
    ex[0] = 305; ey[0] = 204; ev[0] = 1;
    ex[1] = 295; ey[1] = 196; ev[1] = 1;
    ex[2] = 310; ey[2] = 200; ev[2] = 1;
    ex[3] = 300; ey[3] = 208; ev[3] = 1;
    ex[4] = 309; ey[4] = 207; ev[4] = 1;
    ex[5] = 300; ey[5] = 200; ev[5] = 0;
    ex[6] = 600; ey[6] = 20;  ev[6] = 1;
    ex[7] = 291; ey[7] = 193; ev[7] = 1;
    run_scan();
    check("R1", "mixed table vector", hit_vec, 'h93);
    check("R1", "exact x minimum no hit", hit_vec[2], 0);
    check("R2", "enemy below reference", hit_vec[1] & hit_vec[7], 1);
    check("R3", "invalid slot on reference", hit_vec[5], 0);
    check("R5", "any_hit set", any_hit, 1);
    check("R8", "centre not near border", border_hit, 0);

    // R6 hold: change table after done
    for (int k = 0; k < N; k++) begin ex[k] = 300; ey[k] = 200; ev[k] = 1; end
    repeat (5) @(negedge clk);
    check("R6", "vector held after table change", hit_vec, 'h93);

    // R2 wrap case, R8 left border
    clear_table();
    ref_x = 5; ref_y = 100; min_dx = 40; min_dy = 40; margin = 16;
    ex[0] = 1000; ey[0] = 100; ev[0] = 1;
    run_scan();
    check("R2", "no wrap hit", hit_vec, 0);
    check("R5", "any_hit clear", any_hit, 0);
    check("R8", "left border", border_hit, 1);

    // R8 right threshold exact, then one past; bottom
    ref_x = 624; ref_y = 240;
    run_scan();
    check("R8", "x at threshold", border_hit, 0);
    ref_x = 625;
    run_scan();
    check("R8", "x past threshold", border_hit, 1);
    ref_x = 320; ref_y = 470;
    run_scan();
    check("R8", "bottom border", border_hit, 1);

    // R10 capture and R7 ignored start
    clear_table();
    ref_x = 100; ref_y = 100; min_dx = 5; min_dy = 5; margin = 4;
    ex[3] = 102; ey[3] = 102; ev[3] = 1;
    ex[6] = 150; ey[6] = 150; ev[6] = 1;
    pulse_start();
    ref_x = 150; ref_y = 150; min_dx = 1; min_dy = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (N - 2) @(negedge clk);
    check("R7", "done timing kept", done, 1);
    check("R10", "latched reference used", hit_vec, 'h08);
    @(negedge clk);
    check("R7", "no restart", busy, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule